// File: doc/BRIEF.md
# Sequential Signed Multiplier with Zero Early-Out

This block multiplies two signed two's-complement operands over several clock cycles. A mode input picks the operand size: in byte mode only the low 8 bits of each operand take part and the 16-bit signed product is returned sign-extended to 32 bits. In word mode the full 16-bit operands are multiplied into a 32-bit signed product.

The block multiplies the operand magnitudes in a shift-add datapath that retires a few multiplier bits per cycle. When the operand signs differ, it negates the product in a final step. The total latency depends on the data and is fixed for each case:
- A zero in either operand skips the multiply and finishes at once.
- A negative product pays for the sign correction with extra cycles.

Latency is counted with the cycle in which `start` is sampled high as cycle 1. `done` is high in cycle L.

A caller pulses `start` with the mode and operands, then waits for `done`. The product stays on `product` until the next operation completes.

Top module: `smul_early_out`

## Requirements
- R1: In byte mode (`mode`=0) the product equals the signed product of `op_a[7:0]` and `op_b[7:0]`, sign-extended to 32 bits.
- R2: In word mode (`mode`=1) the product equals the 32-bit signed product of `op_a` and `op_b`.
- R3: If either active operand is zero, in either mode, `done` is high in cycle 3 and the product is 0.
- R4: In byte mode, with both operands nonzero and operand signs equal, `done` is high in cycle 12.
- R5: In byte mode, with both operands nonzero and operand signs different, `done` is high in cycle 13.
- R6: In word mode, with both operands nonzero and operand signs equal, `done` is high in cycle 16.
- R7: In word mode, with both operands nonzero and operand signs different, `done` is high in cycle 19.
- R8: `done` is high for exactly one cycle per operation. `busy` is high from cycle 2 through cycle L-1 and is never high together with `done`.
- R9: `product` changes only in the cycle where `done` is high and holds its value until then.
- R10: A `start` sampled while `busy` is high is ignored. The running operation keeps its latency and its product.
- R11: In byte mode the upper eight bits of both operands have no effect on the product or the latency.
- R12: After reset, `busy`=0, `done`=0 and `product`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when not busy |
| mode | input | 1 | 0 = byte operands, 1 = word operands |
| op_a | input | 16 | Multiplicand, two's complement |
| op_b | input | 16 | Multiplier, two's complement |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 32 | Signed result, held until the next completion |

## Verification
Directed operand pairs are drawn, in both modes, from the most negative value, -1, zero and the largest positive value:
- Most negative times most negative probes the magnitude width.
- -1 against the extremes probes the sign correction.
- Zero separates the early-out path from the full path.

Constrained-random pairs carry random upper bits in byte mode, which shows that those bits have no effect. A share of the operations gets a second `start` while busy. The exact cycle of `done` tells the four nonzero latency classes apart, and the product hold is checked after each completion.

// File: rtl/smul_pkg.sv
package smul_pkg;

   typedef enum logic {
      SMUL_BYTE = 1'b0,
      SMUL_WORD = 1'b1
   } smul_mode_e;

   // Picks the total latency class of one operation
   function automatic int unsigned smul_pick_latency(
      input logic        is_word,
      input logic        is_zero,
      input logic        is_neg,
      input int unsigned lat_zero,
      input int unsigned lat_n_pos,
      input int unsigned lat_n_neg,
      input int unsigned lat_w_pos,
      input int unsigned lat_w_neg);
      if (is_zero)
         return lat_zero;
      else if (is_word)
         return is_neg ? lat_w_neg : lat_w_pos;
      else
         return is_neg ? lat_n_neg : lat_n_pos;
   endfunction

endpackage

// File: rtl/smul_operand_prep.sv
module smul_operand_prep
   import smul_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8
) (
   input  smul_mode_e        mode,
   input  logic [WIDE_W-1:0] op_a,
   input  logic [WIDE_W-1:0] op_b,
   output logic [WIDE_W-1:0] mag_a,
   output logic [WIDE_W-1:0] mag_b,
   output logic              any_zero,
   output logic              prod_neg
);
   logic [WIDE_W-1:0] mag [2];
   logic [1:0]        is_zero;
   logic [1:0]        is_sign;

   for (genvar g = 0; g < 2; g++) begin : g_opnd
      logic [WIDE_W-1:0] raw;
      logic [WIDE_W-1:0] ext;
      assign raw = (g == 0) ? op_a : op_b;
      // byte operands are sign-extended so one datapath serves both modes
      assign ext = (mode == SMUL_WORD) ? raw
                 : {{(WIDE_W-NARROW_W){raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
      assign is_sign[g] = ext[WIDE_W-1];
      assign is_zero[g] = (ext == '0);
      // magnitude of the most negative value still fits as unsigned
      assign mag[g]     = is_sign[g] ? (~ext + WIDE_W'(1)) : ext;
   end

   assign mag_a    = mag[0];
   assign mag_b    = mag[1];
   assign any_zero = |is_zero;
   assign prod_neg = (is_sign[0] ^ is_sign[1]) & ~any_zero;

endmodule

// File: rtl/smul_digit_core.sv
module smul_digit_core #(
   parameter int MAG_W   = 16,
   parameter int DIGIT_W = 2,
   localparam int ACC_W  = 2 * MAG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step_en,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output logic [ACC_W-1:0] acc
);
   logic [ACC_W-1:0] mcand_q;
   logic [MAG_W-1:0] mplier_q;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] partial;

   if (DIGIT_W == 1) begin : g_radix2
      assign partial = mplier_q[0] ? mcand_q : '0;
   end else begin : g_radix_hi
      always_comb begin
         partial = '0;
         for (int j = 0; j < DIGIT_W; j++) begin
            if (mplier_q[j])
               partial = partial + (mcand_q << j);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         acc_q    <= '0;
      end else if (load) begin
         mcand_q  <= {{MAG_W{1'b0}}, mag_a};
         mplier_q <= mag_b;
         acc_q    <= '0;
      end else if (step_en) begin
         // once the multiplier is drained further steps add zero
         acc_q    <= acc_q + partial;
         mcand_q  <= mcand_q << DIGIT_W;
         mplier_q <= mplier_q >> DIGIT_W;
      end
   end

   assign acc = acc_q;

endmodule

// File: rtl/smul_latency_timer.sv
module smul_latency_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] lat,
   output logic             busy,
   output logic             finish
);
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (load) begin
         // start cycle is 1, done cycle is lat: lat-2 busy cycles remain
         cnt_q  <= lat - CNT_W'(2);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1))
            busy_q <= 1'b0;
      end
   end

   assign busy   = busy_q;
   assign finish = busy_q && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/smul_early_out.sv
module smul_early_out
   import smul_pkg::*;
#(
   parameter int WIDE_W     = 16,
   parameter int NARROW_W   = 8,
   parameter int DIGIT_W    = 2,
   parameter int LAT_ZERO   = 3,
   parameter int LAT_N_POS  = 12,
   parameter int LAT_N_NEG  = 13,
   parameter int LAT_W_POS  = 16,
   parameter int LAT_W_NEG  = 19
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                mode,
   input  logic [WIDE_W-1:0]   op_a,
   input  logic [WIDE_W-1:0]   op_b,
   output logic                busy,
   output logic                done,
   output logic [2*WIDE_W-1:0] product
);
   localparam int PROD_W  = 2 * WIDE_W;
   localparam int STEPS_W = WIDE_W / DIGIT_W;
   localparam int LAT_MAX = (LAT_W_NEG > LAT_N_NEG) ? LAT_W_NEG : LAT_N_NEG;
   localparam int LAT_MIN_FULL =
      (LAT_N_POS < LAT_W_POS) ? LAT_N_POS : LAT_W_POS;
   localparam int CNT_W   = $clog2(LAT_MAX + 1);

   // elaboration-time parameter checks
   if (NARROW_W >= WIDE_W || NARROW_W < 2) begin : g_bad_width
      $error("smul_early_out: NARROW_W must lie in [2, WIDE_W)");
   end
   if (WIDE_W % DIGIT_W != 0 || DIGIT_W < 1) begin : g_bad_digit
      $error("smul_early_out: DIGIT_W must divide WIDE_W");
   end
   if (LAT_ZERO < 3) begin : g_bad_zero_lat
      $error("smul_early_out: LAT_ZERO below 3 is not reachable");
   end
   if (LAT_MIN_FULL - 3 < STEPS_W) begin : g_bad_full_lat
      $error("smul_early_out: full latency too short for the digit steps");
   end
   if (LAT_N_NEG < LAT_N_POS || LAT_W_NEG < LAT_W_POS) begin : g_bad_neg_lat
      $error("smul_early_out: negative latency below positive latency");
   end

   smul_mode_e        mode_e;
   logic [WIDE_W-1:0] mag_a, mag_b;
   logic              any_zero, prod_neg;
   logic              accept, finish, busy_w;
   logic [CNT_W-1:0]  lat_sel;
   logic [PROD_W-1:0] acc;
   logic              zero_q, neg_q;
   logic              done_q;
   logic [PROD_W-1:0] prod_q;

   assign mode_e = smul_mode_e'(mode);
   assign accept = start && !busy_w;

   smul_operand_prep #(
      .WIDE_W  (WIDE_W),
      .NARROW_W(NARROW_W)
   ) u_prep (
      .mode    (mode_e),
      .op_a    (op_a),
      .op_b    (op_b),
      .mag_a   (mag_a),
      .mag_b   (mag_b),
      .any_zero(any_zero),
      .prod_neg(prod_neg)
   );

   assign lat_sel = CNT_W'(smul_pick_latency(mode_e == SMUL_WORD, any_zero,
                      prod_neg, LAT_ZERO, LAT_N_POS, LAT_N_NEG,
                      LAT_W_POS, LAT_W_NEG));

   smul_latency_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .lat   (lat_sel),
      .busy  (busy_w),
      .finish(finish)
   );

   smul_digit_core #(
      .MAG_W  (WIDE_W),
      .DIGIT_W(DIGIT_W)
   ) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .step_en(busy_w),
      .mag_a  (mag_a),
      .mag_b  (mag_b),
      .acc    (acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zero_q <= 1'b0;
         neg_q  <= 1'b0;
         done_q <= 1'b0;
         prod_q <= '0;
      end else begin
         if (accept) begin
            zero_q <= any_zero;
            neg_q  <= prod_neg;
         end
         done_q <= finish;
         if (finish) begin
            if (zero_q)
               prod_q <= '0;
            else if (neg_q)
               prod_q <= ~acc + PROD_W'(1);
            else
               prod_q <= acc;
         end
      end
   end

   assign busy    = busy_w;
   assign done    = done_q;
   assign product = prod_q;

endmodule

// File: rtl/smul_early_out_chk.sv
module smul_early_out_chk #(
   parameter int WIDE_W    = 16,
   parameter int NARROW_W  = 8,
   parameter int LAT_ZERO  = 3,
   parameter int LAT_N_POS = 12,
   parameter int LAT_N_NEG = 13,
   parameter int LAT_W_POS = 16,
   parameter int LAT_W_NEG = 19
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                mode,
   input logic [WIDE_W-1:0]   op_a,
   input logic [WIDE_W-1:0]   op_b,
   input logic                busy,
   input logic                done,
   input logic [2*WIDE_W-1:0] product
);
   localparam int PW = 2 * WIDE_W;

   logic signed [PW-1:0] sa, sb, exp_now, exp_q;
   logic                 zero_now, neg_now, zero_q, neg_q, word_q;
   logic [15:0]          cyc_q;

   always_comb begin
      sa = mode ? PW'($signed(op_a)) : PW'($signed(op_a[NARROW_W-1:0]));
      sb = mode ? PW'($signed(op_b)) : PW'($signed(op_b[NARROW_W-1:0]));
      exp_now  = sa * sb;
      zero_now = (sa == '0) || (sb == '0);
      neg_now  = !zero_now && (sa[PW-1] != sb[PW-1]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         exp_q  <= '0;
         zero_q <= 1'b0;
         neg_q  <= 1'b0;
         word_q <= 1'b0;
      end else if (start && !busy) begin
         cyc_q  <= 16'd2;
         exp_q  <= exp_now;
         zero_q <= zero_now;
         neg_q  <= neg_now;
         word_q <= mode;
      end else if (cyc_q != '0 && cyc_q != 16'hFFFF) begin
         cyc_q <= cyc_q + 16'd1;
      end
   end

   assert_byte_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done && !word_q |-> product == exp_q);
   assert_word_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done && word_q |-> product == exp_q);
   assert_zero_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done && zero_q |-> cyc_q == 16'(LAT_ZERO) && product == '0);
   assert_byte_pos_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done && !zero_q && !word_q && !neg_q |-> cyc_q == 16'(LAT_N_POS));
   assert_byte_neg_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done && !word_q && neg_q |-> cyc_q == 16'(LAT_N_NEG));
   assert_word_pos_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done && !zero_q && word_q && !neg_q |-> cyc_q == 16'(LAT_W_POS));
   assert_word_neg_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done && word_q && neg_q |-> cyc_q == 16'(LAT_W_NEG));
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   assert_product_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(product));
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> busy || done);

endmodule

bind smul_early_out smul_early_out_chk #(
   .WIDE_W   (WIDE_W),
   .NARROW_W (NARROW_W),
   .LAT_ZERO (LAT_ZERO),
   .LAT_N_POS(LAT_N_POS),
   .LAT_N_NEG(LAT_N_NEG),
   .LAT_W_POS(LAT_W_POS),
   .LAT_W_NEG(LAT_W_NEG)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .mode   (mode),
   .op_a   (op_a),
   .op_b   (op_b),
   .busy   (busy),
   .done   (done),
   .product(product)
);

// File: tb/tb_smul_early_out.sv
`timescale 1ns/1ps
module tb_smul_early_out;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mode = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic        busy, done;
   logic [31:0] product;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   smul_early_out dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
      .product(product)
   );

   function automatic int sval(input logic m, input logic [15:0] v);
      return m ? int'($signed(v)) : int'($signed(v[7:0]));
   endfunction

   function automatic logic [31:0] exp_prod(input logic m,
                                            input logic [15:0] a, b);
      return 32'(sval(m, a) * sval(m, b));
   endfunction

   function automatic int exp_lat(input logic m, input logic [15:0] a, b);
      int x = sval(m, a);
      int y = sval(m, b);
      bit neg = (x < 0) != (y < 0);
      if (x == 0 || y == 0) return 3;
      if (m) return neg ? 19 : 16;
      return neg ? 13 : 12;
   endfunction

   function automatic string lat_tag(input logic m, input logic [15:0] a, b);
      int l = exp_lat(m, a, b);
      if (l == 3)  return "R3";
      if (l == 12) return "R4";
      if (l == 13) return "R5";
      if (l == 16) return "R6";
      return "R7";
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic m, input logic [15:0] a, b,
                         input bit inject);
      logic [31:0] pe = exp_prod(m, a, b);
      int          le = exp_lat(m, a, b);
      int          n;
      bit          seen = 0;
      @(negedge clk);
      mode = m; op_a = a; op_b = b; start = 1'b1;
      n = 1;
      while (!seen && n < 80) begin
         @(negedge clk);
         n++;
         start = 1'b0;
         if (n == 2)
            chk(busy === 1'b1 && done === 1'b0, "R8 busy in cycle 2",
                {30'd0, busy, done}, 32'd2);
         if (done === 1'b1) seen = 1;
         else if (inject && n == 4) begin
            // R10: second start while busy must not disturb the run
            start = 1'b1; mode = ~m; op_a = ~a; op_b = a ^ b ^ 16'h5A5A;
         end
      end
      chk(seen && n == le,
          inject ? {lat_tag(m, a, b), " R10 latency"} : {lat_tag(m, a, b), " latency"},
          32'(n), 32'(le));
      chk(product === pe,
          m ? (inject ? "R2 R10 product" : "R2 product")
            : (inject ? "R1 R11 R10 product" : "R1 R11 product"),
          product, pe);
      @(negedge clk);
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R8 done single pulse",
          {30'd0, busy, done}, 32'd0);
      chk(product === pe, "R9 product hold", product, pe);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
   end

   initial begin : stim
      logic [15:0] bcorner [4];
      logic [15:0] wcorner [4];
      void'($urandom(32'd20240611));
      bcorner = '{16'h0080, 16'h00FF, 16'h0000, 16'h007F};
      wcorner = '{16'h8000, 16'hFFFF, 16'h0000, 16'h7FFF};
      repeat (4) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && product === 32'd0,
          "R12 reset state", product, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && product === 32'd0,
          "R12 idle after reset", product, 32'd0);

      for (int i = 0; i < 4; i++) begin
         for (int j = 0; j < 4; j++) begin
            // byte corners with junk upper bits (R11)
            run_op(1'b0, {8'($urandom), bcorner[i][7:0]},
                   {8'($urandom), bcorner[j][7:0]}, (i + j) % 3 == 0);
            run_op(1'b1, wcorner[i], wcorner[j], (i + j) % 3 == 1);
         end
      end

      for (int k = 0; k < 150; k++) begin
         logic        m = 1'($urandom);
         logic [15:0] a = 16'($urandom);
         logic [15:0] b = 16'($urandom);
         int          sel = int'($urandom % 8);
         if (sel == 0) a[7:0] = 8'h00;
         if (sel == 1) b = m ? 16'h0000 : {b[15:8], 8'h00};
         if (sel == 2) a = m ? 16'hFFFF : {a[15:8], 8'hFF};
         run_op(m, a, b, (k % 3) == 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
   end

endmodule